// File: doc/BRIEF.md
# EDO DRAM access sequencer

This block connects a synchronous host port to a 1M x 4 extended-data-out asynchronous DRAM. The host hands over a 20-bit word address, a write flag and a 4-bit write data word with a valid/ready handshake. The sequencer splits the address into a 10-bit row (upper half) and a 10-bit column (lower half) and places them on one shared address bus. It produces the row strobe, the column strobe, the write enable and the output enable, all active low, with every minimum time counted in whole clock cycles. At a 100 MHz clock these counts come from the 60 ns speed grade. Read data returns on a one-cycle read-valid pulse.

A row stays open after an access. A later request to the same row only runs a column cycle in page mode. A request to a different row, a refresh request, or the page-length limit closes the row and precharges it. Writes always use the early-write form, so the DRAM never drives its data pins during a write. The output enable is low only during and after reads. Before the host drives the pins for a write that follows a read, the output enable is raised and a turnaround time passes. An external refresh controller raises a request. Once the row is closed and precharged, the sequencer answers with a grant and starts no access until the request drops.

Top module: `edo_seq`

## Requirements
- R1: During and right after synchronous reset (rst_n low), all four strobes are high, dram_dq_oe, req_ready, rd_valid and ref_grant are 0.
- R2: The row bits req_addr[19:10] are on dram_addr when the row strobe falls, and the column bits req_addr[9:0] are on dram_addr when the column strobe falls. A word written at an address reads back from that same address.
- R3: A write is an early write. The write enable is low before the column strobe falls and stays low, with dram_dq_oe high and dram_oe_n high, for as long as the column strobe is low.
- R4: A read raises rd_valid for one cycle. rd_data then holds the DRAM word sampled once the column strobe has been low at least T_CAC cycles and the row strobe low at least T_RAC cycles. Reads return in request order.
- R5: Consecutive requests to the open row cause no new fall of the row strobe.
- R6: A request to another row closes the open row and reopens the new one. The row strobe stays low at least T_RAS cycles and then high at least T_RP cycles.
- R7: The column strobe falls only while the row strobe is low, and only after the row strobe has been low more than T_RCD cycles. It stays low at least T_CAS cycles and high at least T_CP cycles between page cycles.
- R8: dram_dq_oe is never high while dram_oe_n is low with the row strobe low. A write that follows a read waits at least T_OEZ cycles after dram_oe_n rises.
- R9: While ref_req is high, the open row closes. After precharge, ref_grant goes high with all strobes high. No host request is accepted and the row strobe does not fall until ref_req drops.
- R10: The row strobe is never low longer than T_RAS_MAX cycles. Same-row streams are split by a forced close.
- R11: Two falls of the row strobe are at least T_RC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | 20 | Word address, row in upper 10 bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh controller wants the DRAM |
| ref_grant | output | 1 | DRAM idle and precharged for refresh |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The assertions rely on three things about the inputs. A host request keeps its address, flag and data steady from the moment req_valid rises until req_ready is seen. The refresh controller keeps ref_req high until it has finished with the grant. The DRAM returns valid data only after the access times. The bench drives requests through one task that holds every field between falling clock edges until the handshake completes. It raises ref_req only between transactions or while a request waits. Its DRAM model returns the inverted word whenever it is sampled before the access times have elapsed, so a read sampled too early comes back wrong.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int AW        = 10,
  parameter int DW        = 4,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 4,
  parameter int T_RC      = 11,
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_CAC     = 2,
  parameter int T_RAC     = 6,
  parameter int T_OEZ     = 2,
  parameter int T_RAS_MAX = 10000,
  parameter int T_GUARD   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2*AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ref_req,
  output logic          ref_grant,
  output logic [AW-1:0] dram_addr,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  output logic [DW-1:0] dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_in
);

  localparam int CW = $clog2(T_RAS_MAX + T_RC + 2) + 1;
  localparam int SW = $clog2(T_RP + T_RC + T_CAC + T_CAS + T_CP + T_OEZ + 2) + 1;
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [SW-1:0] SMAX  = '1;
  localparam logic [CW-1:0] LIMIT = CW'(T_RAS_MAX - T_GUARD);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_OPEN, S_SETUP, S_CASLO, S_PRE} st_t;

  st_t            st;
  logic [SW-1:0]  st_cnt;
  logic [CW-1:0]  cyc_cnt;
  logic [AW-1:0]  open_row;
  logic           cur_wr;

  wire [AW-1:0] req_row  = req_addr[2*AW-1:AW];
  wire          row_hit  = req_row == open_row;
  wire          in_open  = st == S_OPEN;
  wire          at_limit = cyc_cnt >= LIMIT;
  wire          blocked  = ref_req || at_limit;
  wire          want_hit = req_valid && row_hit && !blocked;
  wire          cas_rest = st_cnt >= SW'(T_CP);

  wire do_close  = in_open && cas_rest && cyc_cnt >= CW'(T_RAS) &&
                   (blocked || (req_valid && !row_hit));
  wire need_turn = in_open && want_hit && req_write && !dram_oe_n;
  wire cas_done  = st_cnt >= SW'(T_CAS) &&
                   (cur_wr || (st_cnt >= SW'(T_CAC) && cyc_cnt >= CW'(T_RAC)));

  assign req_ready = in_open && want_hit && cas_rest && cyc_cnt >= CW'(T_RCD) &&
                     (!req_write || (dram_oe_n && st_cnt >= SW'(T_OEZ)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      st_cnt      <= SMAX;
      cyc_cnt     <= CMAX;
      open_row    <= '0;
      cur_wr      <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_grant   <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      ref_grant <= (st == S_IDLE) && ref_req;
      if (cyc_cnt != CMAX) cyc_cnt <= cyc_cnt + 1'b1;
      if (st_cnt != SMAX) st_cnt <= st_cnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (!ref_req && req_valid) begin
            dram_addr <= req_row;
            open_row  <= req_row;
            st        <= S_ROW;
          end
        end
        S_ROW: begin
          if (ref_req) begin
            st <= S_IDLE;
          end else if (cyc_cnt >= CW'(T_RC)) begin
            dram_ras_n <= 1'b0;
            cyc_cnt    <= CW'(1);
            st_cnt     <= SMAX;
            st         <= S_OPEN;
          end
        end
        S_OPEN: begin
          if (do_close) begin
            dram_ras_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            st_cnt     <= SW'(1);
            st         <= S_PRE;
          end else if (req_ready) begin
            dram_addr   <= req_addr[AW-1:0];
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            cur_wr      <= req_write;
            st          <= S_SETUP;
          end else if (need_turn) begin
            dram_oe_n <= 1'b1;
            st_cnt    <= SW'(1);
          end
        end
        S_SETUP: begin
          dram_cas_n <= 1'b0;
          st_cnt     <= SW'(1);
          st         <= S_CASLO;
        end
        S_CASLO: begin
          if (cas_done) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!cur_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            st_cnt <= SW'(1);
            st     <= S_OPEN;
          end
        end
        S_PRE: begin
          if (st_cnt >= SW'(T_RP)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_contend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n && !dram_ras_n));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_dq_oe) |-> $past(dram_oe_n));

  p_cas_in_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  p_rcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> cyc_cnt > CW'(T_RCD));

  p_early_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $past(dram_we_n) == dram_we_n);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n && dram_dq_oe);

  p_ras_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(cyc_cnt) >= CW'(T_RAS));

  p_ras_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> cyc_cnt <= CW'(T_RAS_MAX));

  p_grant_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> dram_ras_n && dram_cas_n && !req_ready);

  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/edo_seq_test.sv
module edo_seq_test;
  localparam int T_RCD = 2, T_RAS = 6, T_RP = 4, T_RC = 11, T_CAS = 1, T_CP = 1;
  localparam int T_CAC = 2, T_RAC = 6, T_OEZ = 2, T_RMAX = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_grant;
  logic [3:0] rd_data, dram_dq_out, dram_dq_in;
  logic [9:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #2 clk = ~clk;

  edo_seq #(.T_RAS_MAX(T_RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_grant(ref_grant),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [3:0] fill(int a);
    return a[3:0] ^ a[13:10] ^ 4'h9;
  endfunction

  // DRAM model
  logic [3:0] mem [int];
  logic [9:0] m_row;
  logic [3:0] m_data, hold;
  logic       we_at_fall;
  int m_ras = 0, m_rash = 1000, m_cas = 0, m_cash = 1000, m_rc = 0, max_low = 0;
  int ras_falls = 0, rp_viol = 0, rc_viol = 0, ras_viol = 0, rcd_viol = 0;
  int cas_viol = 0, cp_viol = 0, ew_viol = 0, cont_viol = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  bit seen_fall = 0;
  wire m_valid = (m_ras + 1 >= T_RAC) && (m_cas + 1 >= T_CAC);

  always @(negedge dram_ras_n) begin
    m_row = dram_addr;
    ras_falls++;
  end

  always @(negedge dram_cas_n) begin
    int a;
    a = {m_row, dram_addr};
    we_at_fall = dram_we_n;
    if (!dram_we_n) begin
      if (!dram_oe_n || !dram_dq_oe) ew_viol++;
      mem[a] = dram_dq_out;
    end
    m_data = mem.exists(a) ? mem[a] : fill(a);
  end

  assign dram_dq_in = (!dram_ras_n && !dram_oe_n) ?
                      (!dram_cas_n ? (m_valid ? m_data : ~m_data) : hold) : 4'h0;

  always @(posedge clk) begin
    prev_ras <= dram_ras_n;
    prev_cas <= dram_cas_n;
    m_ras  <= dram_ras_n ? 0 : m_ras + 1;
    m_rash <= dram_ras_n ? m_rash + 1 : 0;
    m_cas  <= dram_cas_n ? 0 : m_cas + 1;
    m_cash <= dram_cas_n ? m_cash + 1 : 0;
    m_rc   <= m_rc + 1;
    if (!dram_cas_n) hold <= m_valid ? m_data : ~m_data;
    if (rst_n) begin
      if (!dram_ras_n && prev_ras) begin
        if (m_rash < T_RP) rp_viol++;
        if (seen_fall && m_rc < T_RC) rc_viol++;
        m_rc <= 1;
        seen_fall <= 1;
      end
      if (dram_ras_n && !prev_ras && m_ras < T_RAS) ras_viol++;
      if (m_ras > max_low) max_low <= m_ras;
      if (!dram_cas_n && prev_cas) begin
        if (m_ras < T_RCD) rcd_viol++;
        if (m_cash < T_CP) cp_viol++;
      end
      if (dram_cas_n && !prev_cas && m_cas < T_CAS) cas_viol++;
      if (!dram_cas_n && dram_ras_n) cas_viol++;
      if (!dram_cas_n && !prev_cas && dram_we_n != we_at_fall) ew_viol++;
    end
  end

  always @(negedge clk)
    if (rst_n && dram_dq_oe && !dram_oe_n && !dram_ras_n) cont_viol++;

  // Scoreboard
  logic [3:0] ref_mem [int];
  logic [3:0] exp_q [$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected read", 1, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R4/R2 read data", rd_data, e);
      end
    end
  end

  task automatic note_accept(logic [19:0] a, logic w, logic [3:0] d);
    if (w) ref_mem[a] = d;
    else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : fill(a));
  endtask

  task automatic issue(logic [19:0] a, logic w, logic [3:0] d);
    req_addr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    note_accept(a, w, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int f0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    check(!dram_dq_oe && !req_ready && !rd_valid && !ref_grant, "R1 outputs",
          {dram_dq_oe, req_ready, rd_valid, ref_grant}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dram_ras_n && !req_ready, "R1 after release", dram_ras_n, 1);

    // R3 R4 R5 page hits on one row
    f0 = ras_falls;
    for (int c = 0; c < 4; c++) issue({10'd5, 10'(c)}, 1'b1, 4'(c * 3 + 1));
    for (int c = 0; c < 4; c++) issue({10'd5, 10'(c)}, 1'b0, 4'h0);
    issue({10'd5, 10'd2}, 1'b1, 4'hE);
    issue({10'd5, 10'd2}, 1'b0, 4'h0);
    drain("R4 page reads returned");
    check(ras_falls - f0 == 1, "R5 single row open", ras_falls - f0, 1);

    // R6 row changes
    f0 = ras_falls;
    issue({10'd9, 10'd1}, 1'b1, 4'h7);
    issue({10'd10, 10'd1}, 1'b1, 4'h3);
    issue({10'd9, 10'd1}, 1'b0, 4'h0);
    issue({10'd10, 10'd1}, 1'b0, 4'h0);
    drain("R6 cross-row reads returned");
    check(ras_falls - f0 == 4, "R6 reopen per row change", ras_falls - f0, 4);

    // R9 refresh grant
    issue({10'd7, 10'd1}, 1'b0, 4'h0);
    drain("R9 read before refresh");
    ref_req = 1'b1;
    for (int i = 0; i < 60 && !ref_grant; i++) @(negedge clk);
    check(ref_grant && dram_ras_n, "R9 grant with row closed", {ref_grant, dram_ras_n}, 3);
    f0 = ras_falls;
    begin
      int bad = 0;
      req_addr = {10'd7, 10'd2}; req_write = 1'b0; req_valid = 1'b1;
      repeat (15) begin
        @(negedge clk);
        if (req_ready || !dram_ras_n) bad++;
      end
      check(bad == 0 && ras_falls == f0, "R9 no access during grant", bad, 0);
    end
    ref_req = 1'b0;
    while (!req_ready) @(negedge clk);
    note_accept({10'd7, 10'd2}, 1'b0, 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(!ref_grant, "R9 grant released", ref_grant, 0);
    drain("R9 read after refresh");

    // R10 long same-row stream
    f0 = ras_falls;
    for (int i = 0; i < 60; i++) issue({10'd2, 10'(i % 8)}, i % 3 == 0, 4'(i));
    drain("R10 stream reads returned");
    check(ras_falls - f0 >= 2, "R10 forced close", ras_falls - f0, 2);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [19:0] a;
      a = {10'($urandom_range(0, 3)), 10'($urandom_range(0, 7))};
      if ($urandom_range(0, 24) == 0) begin
        ref_req = 1'b1;
        for (int i = 0; i < 60 && !ref_grant; i++) @(negedge clk);
        check(ref_grant && dram_ras_n, "R9 random refresh grant", ref_grant, 1);
        repeat (3) @(negedge clk);
        ref_req = 1'b0;
        @(negedge clk);
      end
      issue(a, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
    end
    drain("R4 random reads returned");

    check(ras_viol == 0, "R6 row strobe low time", ras_viol, 0);
    check(rp_viol == 0, "R6 precharge time", rp_viol, 0);
    check(rcd_viol == 0 && cas_viol == 0 && cp_viol == 0, "R7 column strobe timing",
          rcd_viol + cas_viol + cp_viol, 0);
    check(ew_viol == 0, "R3 early write form", ew_viol, 0);
    check(cont_viol == 0, "R8 no data contention", cont_viol, 0);
    check(max_low <= T_RMAX, "R10 longest row strobe low", max_low, T_RMAX);
    check(rc_viol == 0, "R11 row cycle time", rc_viol, 0);
    done = 1;
    summary();
  end
endmodule